// File: doc/BRIEF.md
# Sector Address to ATA Register Translator

This block turns a linear sector number into the register values a host writes to an ATA device before a one-sector PIO read. Three addressing schemes are supported: cylinder/head/sector, 28-bit logical addressing and 48-bit logical addressing. The caller supplies the sector, the scheme, the drive capacity, the geometry (head count and sectors per track) and a drive-select bit. The block returns the sector count, three low-order address bytes, three high-order address bytes, the device byte and the command code.

Logical modes need only byte slicing and complete two cycles after the request is taken. Cylinder/head/sector mode needs two divisions: first by sectors per track, then by heads. Both run on a single shared restoring divider that yields one quotient bit per cycle. A request is taken on `start` while idle. The block raises `busy` until a one-cycle `done` pulse, which comes with `err` when the request is refused. A request is refused when the sector exceeds the capacity, when the scheme code is unused, or when a geometry divisor is zero.

Top module: `ata_addr_xlate`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low and every register output is zero.
- R2: `start` is taken only while `busy` is low, and `busy` is high in the next cycle. A `start` seen while `busy` is high has no effect. All request inputs are captured when `start` is taken, so changing them later does not alter the result.
- R3: `done` is high for exactly one cycle per taken request and `busy` is low in that cycle. `err` is high only together with `done`. A new `start` may be taken in the cycle `done` is high.
- R4: A successful result always carries a sector count of 1.
- R5: With mode code 1 (28-bit logical), address bits 7:0, 15:8 and 23:16 appear on `addr_lo`, `addr_mid` and `addr_hi`. The high-order bytes are zero and the device byte is 0xE0 | (slave<<4) | address bits 27:24. The command is 0x20.
- R6: With mode code 2 (48-bit logical), bits 7:0, 15:8 and 23:16 appear on the low bytes, and bits 31:24, 39:32 and 47:40 on `addr_lo_x`, `addr_mid_x` and `addr_hi_x`. The device byte is 0x40 | (slave<<4) and the command is 0x24.
- R7: With mode code 0 (CHS), track = sector / spt and `addr_lo` = 1 + (sector mod spt). Cylinder = track / heads, with its bits 7:0 on `addr_mid` and 15:8 on `addr_hi`. The high-order bytes are zero, the device byte is 0xA0 | (slave<<4) | (track mod heads)[3:0], and the command is 0x20.
- R8: Counting the edge that takes `start` as edge 1, `done` rises after edge 2 in the logical modes and after edge 2*SECT_W+4 in CHS mode.
- R9: A request is refused with `err` and all register outputs zero when the sector is greater than `capacity`, when the mode code is 3, or when CHS mode has `heads` or `spt` equal to zero. A sector equal to `capacity` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken while idle |
| mode | input | 2 | 0 CHS, 1 28-bit logical, 2 48-bit logical, 3 invalid |
| sector | input | SECT_W | Linear sector number |
| capacity | input | SECT_W | Highest acceptable sector number |
| heads | input | GEO_W | Heads per cylinder |
| spt | input | GEO_W | Sectors per track |
| slave | input | 1 | Selects the second drive on the channel |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Refusal flag, valid with done |
| sec_count | output | 8 | Sector count value |
| addr_lo | output | 8 | Low address / sector number byte |
| addr_mid | output | 8 | Mid address / cylinder low byte |
| addr_hi | output | 8 | High address / cylinder high byte |
| addr_lo_x | output | 8 | Extended address bits 31:24 |
| addr_mid_x | output | 8 | Extended address bits 39:32 |
| addr_hi_x | output | 8 | Extended address bits 47:40 |
| dev_sel | output | 8 | Device/head byte |
| cmd_code | output | 8 | Read command code |

## Verification
The completion pulse of one request and the acceptance of the next can fall in the same cycle. When `done` goes high the controller is already idle, so a `start` held high in that cycle must be taken. The bench provokes this by issuing each request at the sampling point where the previous `done` is seen. It then judges both results against independently computed fields and checks that the second request still shows the expected latency. A second overlap is a `start`, with changed inputs, pulsed during a CHS division. It must produce no extra `done` pulse and must leave the first result unchanged.

// File: rtl/ata_xlate_pkg.sv
package ata_xlate_pkg;

  typedef enum logic [1:0] {
    AM_CHS   = 2'd0,
    AM_LBA28 = 2'd1,
    AM_LBA48 = 2'd2,
    AM_BAD   = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_EVAL = 2'd1,
    S_DIV1 = 2'd2,
    S_DIV2 = 2'd3
  } xl_state_e;

  typedef struct packed {
    logic [7:0] seccnt;
    logic [7:0] lo;
    logic [7:0] mid;
    logic [7:0] hi;
    logic [7:0] xlo;
    logic [7:0] xmid;
    logic [7:0] xhi;
    logic [7:0] dev;
    logic [7:0] cmd;
  } taskfile_t;

  localparam logic [7:0] DEV_FIXED  = 8'hA0;
  localparam logic [7:0] DEV_LBA    = 8'h40;
  localparam logic [7:0] CMD_RD     = 8'h20;
  localparam logic [7:0] CMD_RD_EXT = 8'h24;

endpackage

// File: rtl/xlate_divider.sv
module xlate_divider #(
  parameter int NW = 48,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quot,
  output logic [DW-1:0] rem
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] q_q;
  logic [DW-1:0] r_q;
  logic [DW-1:0] d_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          done_q;

  logic [DW:0]   trial;
  logic          fits;
  logic [DW:0]   next_r;

  always_comb begin
    trial  = {r_q, q_q[NW-1]};
    fits   = trial >= {1'b0, d_q};
    next_r = fits ? (trial - {1'b0, d_q}) : trial;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_q    <= '0;
      r_q    <= '0;
      d_q    <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        q_q   <= dividend;
        r_q   <= '0;
        d_q   <= divisor;
        cnt_q <= CW'(NW);
        act_q <= 1'b1;
      end else if (act_q) begin
        r_q   <= next_r[DW-1:0];
        q_q   <= {q_q[NW-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quot = q_q;
  assign rem  = r_q;
endmodule

// File: rtl/xlate_format.sv
module xlate_format
  import ata_xlate_pkg::*;
#(
  parameter int SW = 48,
  parameter int DW = 16
) (
  input  logic [1:0]    mode,
  input  logic [SW-1:0] sector,
  input  logic          slave,
  input  logic [DW-1:0] chs_rem1,
  input  logic [SW-1:0] chs_quot2,
  input  logic [DW-1:0] chs_rem2,
  output taskfile_t     tf
);
  logic [47:0]   s48;
  logic [DW-1:0] sfield;
  logic [7:0]    slv;
  logic          unused;

  always_comb begin
    s48    = 48'(sector);
    sfield = chs_rem1 + DW'(1);
    slv    = {3'b000, slave, 4'b0000};
    tf     = '0;
    tf.seccnt = 8'd1;
    case (mode)
      AM_CHS: begin
        tf.lo  = sfield[7:0];
        tf.mid = chs_quot2[7:0];
        tf.hi  = chs_quot2[15:8];
        tf.dev = DEV_FIXED | slv | {4'b0000, chs_rem2[3:0]};
        tf.cmd = CMD_RD;
      end
      AM_LBA28: begin
        tf.lo  = s48[7:0];
        tf.mid = s48[15:8];
        tf.hi  = s48[23:16];
        tf.dev = DEV_FIXED | DEV_LBA | slv | {4'b0000, s48[27:24]};
        tf.cmd = CMD_RD;
      end
      AM_LBA48: begin
        tf.lo   = s48[7:0];
        tf.mid  = s48[15:8];
        tf.hi   = s48[23:16];
        tf.xlo  = s48[31:24];
        tf.xmid = s48[39:32];
        tf.xhi  = s48[47:40];
        tf.dev  = DEV_LBA | slv;
        tf.cmd  = CMD_RD_EXT;
      end
      default: tf = '0;
    endcase
  end

  assign unused = ^{sfield, chs_quot2, chs_rem2};
endmodule

// File: rtl/ata_addr_xlate.sv
module ata_addr_xlate
  import ata_xlate_pkg::*;
#(
  parameter int SECT_W = 48,
  parameter int GEO_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [SECT_W-1:0] sector,
  input  logic [SECT_W-1:0] capacity,
  input  logic [GEO_W-1:0]  heads,
  input  logic [GEO_W-1:0]  spt,
  input  logic              slave,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [7:0]        sec_count,
  output logic [7:0]        addr_lo,
  output logic [7:0]        addr_mid,
  output logic [7:0]        addr_hi,
  output logic [7:0]        addr_lo_x,
  output logic [7:0]        addr_mid_x,
  output logic [7:0]        addr_hi_x,
  output logic [7:0]        dev_sel,
  output logic [7:0]        cmd_code
);
  xl_state_e         state_q;
  logic [1:0]        mode_q;
  logic [SECT_W-1:0] sec_q;
  logic [SECT_W-1:0] cap_q;
  logic [GEO_W-1:0]  heads_q;
  logic [GEO_W-1:0]  spt_q;
  logic              slave_q;
  logic [GEO_W-1:0]  rem1_q;
  taskfile_t         tf_q;
  logic              done_q;
  logic              err_q;

  logic              refuse;
  logic              div_start;
  logic [SECT_W-1:0] div_num;
  logic [GEO_W-1:0]  div_den;
  logic              div_done;
  logic [SECT_W-1:0] div_quot;
  logic [GEO_W-1:0]  div_rem;
  taskfile_t         tf_next;

  always_comb begin
    refuse = (sec_q > cap_q) || (mode_q == AM_BAD) ||
             ((mode_q == AM_CHS) && ((heads_q == '0) || (spt_q == '0)));
    div_start = ((state_q == S_EVAL) && !refuse && (mode_q == AM_CHS)) ||
                ((state_q == S_DIV1) && div_done);
    div_num = (state_q == S_DIV1) ? div_quot : sec_q;
    div_den = (state_q == S_DIV1) ? heads_q  : spt_q;
  end

  xlate_divider #(.NW(SECT_W), .DW(GEO_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_start),
    .dividend (div_num),
    .divisor  (div_den),
    .done     (div_done),
    .quot     (div_quot),
    .rem      (div_rem)
  );

  xlate_format #(.SW(SECT_W), .DW(GEO_W)) u_fmt (
    .mode      (mode_q),
    .sector    (sec_q),
    .slave     (slave_q),
    .chs_rem1  (rem1_q),
    .chs_quot2 (div_quot),
    .chs_rem2  (div_rem),
    .tf        (tf_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      mode_q  <= '0;
      sec_q   <= '0;
      cap_q   <= '0;
      heads_q <= '0;
      spt_q   <= '0;
      slave_q <= 1'b0;
      rem1_q  <= '0;
      tf_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            mode_q  <= mode;
            sec_q   <= sector;
            cap_q   <= capacity;
            heads_q <= heads;
            spt_q   <= spt;
            slave_q <= slave;
            state_q <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (refuse) begin
            tf_q    <= '0;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else if (mode_q == AM_CHS) begin
            state_q <= S_DIV1;
          end else begin
            tf_q    <= tf_next;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_DIV1: begin
          if (div_done) begin
            rem1_q  <= div_rem;
            state_q <= S_DIV2;
          end
        end
        S_DIV2: begin
          if (div_done) begin
            tf_q    <= tf_next;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != S_IDLE);
  assign done       = done_q;
  assign err        = err_q;
  assign sec_count  = tf_q.seccnt;
  assign addr_lo    = tf_q.lo;
  assign addr_mid   = tf_q.mid;
  assign addr_hi    = tf_q.hi;
  assign addr_lo_x  = tf_q.xlo;
  assign addr_mid_x = tf_q.xmid;
  assign addr_hi_x  = tf_q.xhi;
  assign dev_sel    = tf_q.dev;
  assign cmd_code   = tf_q.cmd;
endmodule

// File: rtl/ata_addr_xlate_chk.sv
module ata_addr_xlate_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [7:0] sec_count,
  input logic [7:0] addr_lo,
  input logic [7:0] addr_mid,
  input logic [7:0] addr_hi,
  input logic [7:0] addr_lo_x,
  input logic [7:0] addr_mid_x,
  input logic [7:0] addr_hi_x,
  input logic [7:0] dev_sel,
  input logic [7:0] cmd_code
);
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R3
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    err |-> done); // R3
  AST_ONE_SECTOR: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (sec_count == 8'd1)); // R4
  AST_LEGACY_DEV: assert property (@(posedge clk) disable iff (rst)
    (done && !err && cmd_code == 8'h20) |-> (dev_sel[7] && dev_sel[5])); // R5
  AST_EXT_DEV: assert property (@(posedge clk) disable iff (rst)
    (done && !err && cmd_code == 8'h24) |-> (dev_sel[7:5] == 3'b010 && dev_sel[3:0] == 4'd0)); // R6
  AST_CHS_SECNUM: assert property (@(posedge clk) disable iff (rst)
    (done && !err && cmd_code == 8'h20 && !dev_sel[6]) |-> (addr_lo != 8'd0)); // R7
  AST_REFUSE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> ({sec_count, addr_lo, addr_mid, addr_hi, addr_lo_x,
                        addr_mid_x, addr_hi_x, dev_sel, cmd_code} == '0)); // R9
endmodule

bind ata_addr_xlate ata_addr_xlate_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .sec_count  (sec_count),
  .addr_lo    (addr_lo),
  .addr_mid   (addr_mid),
  .addr_hi    (addr_hi),
  .addr_lo_x  (addr_lo_x),
  .addr_mid_x (addr_mid_x),
  .addr_hi_x  (addr_hi_x),
  .dev_sel    (dev_sel),
  .cmd_code   (cmd_code)
);

// File: tb/sim_ata_addr_xlate.sv
module sim_ata_addr_xlate;
  localparam int SW = 48;
  localparam int GW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    mode = '0;
  logic [SW-1:0] sector = '0;
  logic [SW-1:0] capacity = '0;
  logic [GW-1:0] heads = '0;
  logic [GW-1:0] spt = '0;
  logic          slave = 1'b0;
  logic          busy, done, err;
  logic [7:0]    sec_count, addr_lo, addr_mid, addr_hi;
  logic [7:0]    addr_lo_x, addr_mid_x, addr_hi_x, dev_sel, cmd_code;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  int done_pulses = 0;

  always #5 clk = ~clk;

  ata_addr_xlate #(.SECT_W(SW), .GEO_W(GW)) u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .sector(sector),
    .capacity(capacity), .heads(heads), .spt(spt), .slave(slave),
    .busy(busy), .done(done), .err(err), .sec_count(sec_count),
    .addr_lo(addr_lo), .addr_mid(addr_mid), .addr_hi(addr_hi),
    .addr_lo_x(addr_lo_x), .addr_mid_x(addr_mid_x), .addr_hi_x(addr_hi_x),
    .dev_sel(dev_sel), .cmd_code(cmd_code)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (done) done_pulses <= done_pulses + 1;
    if (cycles > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected register image {seccnt,lo,mid,hi,xlo,xmid,xhi,dev,cmd}, plus refusal flag
  function automatic logic [72:0] model(input logic [1:0] md, input longint unsigned s,
      input longint unsigned cap, input longint unsigned h, input longint unsigned t, input logic sl);
    logic [7:0] b [9];
    longint unsigned trk, cyl, hd, sn;
    for (int i = 0; i < 9; i++) b[i] = 8'h00;
    if (s > cap || md == 2'd3 || (md == 2'd0 && (h == 0 || t == 0)))
      return {1'b1, 72'h0};
    b[0] = 8'd1;
    if (md == 2'd0) begin
      trk = s / t; sn = (s % t) + 1; cyl = trk / h; hd = trk % h;
      b[1] = sn[7:0]; b[2] = cyl[7:0]; b[3] = cyl[15:8];
      b[7] = 8'hA0 | {3'b0, sl, 4'b0} | {4'b0, hd[3:0]};
      b[8] = 8'h20;
    end else begin
      b[1] = s[7:0]; b[2] = s[15:8]; b[3] = s[23:16];
      if (md == 2'd1) begin
        b[7] = 8'hE0 | {3'b0, sl, 4'b0} | {4'b0, s[27:24]};
        b[8] = 8'h20;
      end else begin
        b[4] = s[31:24]; b[5] = s[39:32]; b[6] = s[47:40];
        b[7] = 8'h40 | {3'b0, sl, 4'b0};
        b[8] = 8'h24;
      end
    end
    return {1'b0, b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7], b[8]};
  endfunction

  // Drives a request at the current (negedge) point, returns edges until done.
  task automatic issue(input logic [1:0] md, input longint unsigned s, input longint unsigned cap,
      input longint unsigned h, input longint unsigned t, input logic sl, output int lat);
    mode = md; sector = SW'(s); capacity = SW'(cap); heads = GW'(h); spt = GW'(t); slave = sl;
    start = 1'b1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 1000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  task automatic compare(input string req, input logic [72:0] e);
    chk({req, " err"}, err, e[72]);
    chk({req, " fields"}, {sec_count, addr_lo, addr_mid, addr_hi, addr_lo_x,
        addr_mid_x, addr_hi_x, dev_sel, cmd_code}, e[71:0]);
  endtask

  task automatic run_one(input string req, input logic [1:0] md, input longint unsigned s,
      input longint unsigned cap, input longint unsigned h, input longint unsigned t,
      input logic sl, input int exp_lat);
    int lat;
    issue(md, s, cap, h, t, sl, lat);
    chk({req, " done"}, done, 1);
    compare(req, model(md, s, cap, h, t, sl));
    if (exp_lat > 0) chk("R8 latency", lat, exp_lat);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 outputs", {sec_count, addr_lo, addr_mid, addr_hi, addr_lo_x,
        addr_mid_x, addr_hi_x, dev_sel, cmd_code}, 0);
  endtask

  task automatic t_lba28();
    run_one("R5 lba28 m", 2'd1, 64'h0000_09AB_CDEF, 64'hFFFF_FFFF_FFFF, 0, 0, 1'b0, 2);
    run_one("R5 lba28 s", 2'd1, 64'h0001_F234_5678, 64'hFFFF_FFFF_FFFF, 0, 0, 1'b1, 2);
  endtask

  task automatic t_lba48();
    run_one("R6 lba48 s", 2'd2, 64'h1234_5678_9ABC, 64'hFFFF_FFFF_FFFF, 0, 0, 1'b1, 2);
    run_one("R6 lba48 m", 2'd2, 64'hFEDC_BA98_7654, 64'hFFFF_FFFF_FFFF, 0, 0, 1'b0, 2);
  endtask

  task automatic t_chs();
    run_one("R7 chs a", 2'd0, 1000000, 64'hFFFF_FFFF, 16, 63, 1'b0, 2*SW+4);
    run_one("R7 chs b", 2'd0, 12345, 64'hFFFF_FFFF, 4, 17, 1'b1, 2*SW+4);
    run_one("R7 chs zero", 2'd0, 0, 64'hFFFF_FFFF, 15, 255, 1'b0, 0);
    run_one("R7 chs edge", 2'd0, 63*16*1024 - 1, 64'hFFFF_FFFF, 16, 63, 1'b1, 0);
  endtask

  task automatic t_refuse();
    run_one("R9 beyond cap", 2'd1, 1001, 1000, 0, 0, 1'b0, 2);
    run_one("R9 equal cap", 2'd2, 1000, 1000, 0, 0, 1'b0, 2);
    run_one("R9 bad mode", 2'd3, 5, 1000, 4, 4, 1'b0, 2);
    run_one("R9 zero heads", 2'd0, 5, 1000, 0, 17, 1'b0, 2);
    run_one("R9 zero spt", 2'd0, 5, 1000, 4, 0, 1'b0, 2);
  endtask

  task automatic t_busy_ignore();
    int lat;
    int p0;
    repeat (3) @(negedge clk);
    p0 = done_pulses;
    mode = 2'd0; sector = SW'(777777); capacity = '1; heads = GW'(9); spt = GW'(31); slave = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk("R2 busy mid-run", busy, 1);
    mode = 2'd2; sector = SW'(42); heads = GW'(3); spt = GW'(5); slave = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin @(negedge clk); lat++; end
    compare("R2 latched inputs", model(2'd0, 777777, 64'hFFFF_FFFF_FFFF, 9, 31, 1'b0));
    repeat (150) @(negedge clk);
    chk("R2 single done", done_pulses - p0, 1);
    chk("R3 idle after", busy, 0);
  endtask

  task automatic t_back_to_back();
    int lat;
    issue(2'd0, 5000, 64'hFFFF, 8, 20, 1'b1, lat);
    compare("R3 first", model(2'd0, 5000, 64'hFFFF, 8, 20, 1'b1));
    chk("R3 done before overlap", done, 1);
    issue(2'd1, 64'h0ABC_DEF0, 64'hFFFF_FFFF, 0, 0, 1'b0, lat);
    compare("R3 overlapped start", model(2'd1, 64'h0ABC_DEF0, 64'hFFFF_FFFF, 0, 0, 1'b0));
    chk("R3 overlap latency", lat, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_lba28();
    t_lba48();
    t_chs();
    t_refuse();
    t_busy_ignore();
    t_back_to_back();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule